// File: doc/BRIEF.md
# Serial ADC Power-Mode Tracker

This block follows the power state of a serial-interface converter from the slave side. It watches the active-low chip-select and the serial clock, both sampled by a fast system clock, and counts the serial-clock falling edges that occur while chip-select is low. When chip-select rises, that count decides the mode. A frame cut short before the wake threshold puts the device into shutdown. A frame that reaches the threshold keeps or brings the device in normal mode.

The block also follows wake-up progress and whether a conversion result can be trusted. The device counts as powered once enough falling edges have accumulated since the last shutdown or reset. The first completed normal-mode frame after a reset or a shutdown is a dummy conversion, so its result is flagged invalid.

The mode the device wakes into at supply start-up is not known in advance. For this reason a reset-time input selects it.

Top module: `pwrmode_tracker`

## Requirements
- R1: While `rst` is high and after it, until the first frame ends: `mode_o` equals `boot_normal_i` (1 = normal, 0 = shutdown), and `powered_o`, `result_valid_o` and `frame_done_o` are 0. `frame_edges_o` is also 0.
- R2: A frame that ends with fewer than 10 counted falling edges sets `mode_o` to 0 and clears `powered_o` and `result_valid_o`.
- R3: A frame that ends with 10 or more counted falling edges sets `mode_o` to 1.
- R4: Each rise of `cs_n_i` gives a `frame_done_o` pulse exactly one clock long. In the same cycle, `frame_edges_o` carries the number of `sclk_i` falling edges seen while `cs_n_i` was low in that frame. The count saturates at 31 and is held until the next frame ends.
- R5: `powered_o` becomes 1 once 16 counted falling edges have accumulated since the last reset or shutdown, across frames, and it can rise during a frame. It returns to 0 only when a frame ends in shutdown or on reset.
- R6: The first frame after reset or shutdown that ends in normal mode gives `result_valid_o` = 0, because it is the dummy conversion. Each later frame that ends in normal mode gives 1. `result_valid_o` changes only at a frame end.
- R7: `sclk_i` falling edges while `cs_n_i` is high are not counted. They advance neither the frame count nor wake-up progress.
- R8: Both pins pass through a two-stage synchronizer. `frame_done_o` is high in the cycle that follows the third rising clock edge at which `cs_n_i` is sampled high, and it is low one cycle earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| boot_normal_i | input | 1 | Mode loaded at reset: 1 normal, 0 shutdown |
| cs_n_i | input | 1 | Serial chip-select, active low, asynchronous |
| sclk_i | input | 1 | Serial clock, asynchronous |
| mode_o | output | 1 | Current mode: 1 normal, 0 shutdown |
| powered_o | output | 1 | Wake-up complete |
| result_valid_o | output | 1 | Result of the last completed frame is valid |
| frame_done_o | output | 1 | One-cycle pulse at the end of each frame |
| frame_edges_o | output | 5 | Falling-edge count of the last completed frame |

## Verification
Directed frames of 9 and 10 edges separate the shutdown and normal decisions at the threshold. A 40-edge frame shows that the count saturates. Frames of 15 and 16 edges, checked during the frame, place the exact edge at which wake-up completes. Runs from both reset modes show that the dummy flag clears at start-up and at every shutdown. Serial-clock pulses sent while chip-select is high, followed by a frame of known length, show that idle edges touch neither the frame count nor wake-up progress. Random frame lengths from 0 to 40, with random idle pulses and occasional resets, exercise every transition against a bench model of mode, wake-up progress and dummy state.

// File: rtl/pwrtrk_pkg.sv
package pwrtrk_pkg;

    localparam int DEF_CNT_W         = 5;
    localparam int DEF_WAKE_EDGE     = 10;
    localparam int DEF_POWERUP_EDGES = 16;
    localparam int DEF_SYNC_STAGES   = 2;

    typedef enum logic {
        PM_SHUTDOWN = 1'b0,
        PM_NORMAL   = 1'b1
    } pmode_e;

    typedef struct packed {
        logic cs_high;
        logic cs_rise;
        logic cs_fall;
        logic sclk_fall;
    } pin_evt_t;

    function automatic pin_evt_t decode_pins(logic cs_now, logic cs_prev,
                                             logic sclk_now, logic sclk_prev);
        pin_evt_t e;
        e.cs_high   = cs_now;
        e.cs_rise   = cs_now & ~cs_prev;
        e.cs_fall   = ~cs_now & cs_prev;
        e.sclk_fall = ~sclk_now & sclk_prev;
        return e;
    endfunction

endpackage

// File: rtl/pwrtrk_sync.sv
module pwrtrk_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic level,
    output logic prev
);
    logic [STAGES-1:0] chain;

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) chain[g] <= RST_VAL;
                else     chain[g] <= din;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) chain[g] <= RST_VAL;
                else     chain[g] <= chain[g-1];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) prev <= RST_VAL;
        else     prev <= chain[STAGES-1];
    end

    assign level = chain[STAGES-1];

endmodule

// File: rtl/pwrtrk_frame_cnt.sv
module pwrtrk_frame_cnt #(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cs_high,
    input  logic             cs_fall,
    input  logic             sclk_fall,
    output logic [CNT_W-1:0] edge_cnt,
    output logic             edge_tick
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    assign edge_tick = sclk_fall & ~cs_high;

    always_ff @(posedge clk) begin
        if (rst)                                  edge_cnt <= '0;
        else if (cs_fall)                         edge_cnt <= '0;
        else if (edge_tick && edge_cnt != CNT_MAX) edge_cnt <= edge_cnt + 1'b1;
    end

    // R7: with chip-select high the frame count does not move
    assert_idle_hold_R7: assert property (@(posedge clk) disable iff (rst)
        cs_high |=> $stable(edge_cnt));

endmodule

// File: rtl/pwrtrk_mode_fsm.sv
module pwrtrk_mode_fsm
    import pwrtrk_pkg::*;
#(
    parameter int CNT_W         = 5,
    parameter int WAKE_EDGE     = 10,
    parameter int POWERUP_EDGES = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             boot_normal,
    input  logic             cs_rise,
    input  logic             edge_tick,
    input  logic [CNT_W-1:0] edge_cnt,
    output pmode_e           mode,
    output logic             powered,
    output logic             result_valid,
    output logic             frame_done,
    output logic [CNT_W-1:0] frame_edges
);
    localparam int WAKE_W = $clog2(POWERUP_EDGES + 1);
    localparam logic [WAKE_W-1:0] WAKE_FULL = WAKE_W'(POWERUP_EDGES);
    localparam logic [CNT_W-1:0]  WAKE_THR  = CNT_W'(WAKE_EDGE);

    logic [WAKE_W-1:0] wake_cnt;
    logic              dummy_done;
    logic              long_frame;

    assign long_frame = (edge_cnt >= WAKE_THR);
    assign powered    = (wake_cnt == WAKE_FULL);

    always_ff @(posedge clk) begin
        if (rst) begin
            mode         <= boot_normal ? PM_NORMAL : PM_SHUTDOWN;
            wake_cnt     <= '0;
            dummy_done   <= 1'b0;
            result_valid <= 1'b0;
            frame_done   <= 1'b0;
            frame_edges  <= '0;
        end else begin
            frame_done <= cs_rise;
            if (cs_rise) begin
                frame_edges <= edge_cnt;
                if (long_frame) begin
                    mode         <= PM_NORMAL;
                    result_valid <= dummy_done;
                    dummy_done   <= 1'b1;
                end else begin
                    mode         <= PM_SHUTDOWN;
                    wake_cnt     <= '0;
                    dummy_done   <= 1'b0;
                    result_valid <= 1'b0;
                end
            end else if (edge_tick && !powered) begin
                wake_cnt <= wake_cnt + 1'b1;
            end
        end
    end

    // R4: the end-of-frame pulse lasts one cycle
    assert_done_pulse_R4: assert property (@(posedge clk) disable iff (rst)
        frame_done |=> !frame_done);

    // R2: a short frame leaves the device in shutdown and unpowered
    assert_short_shutdown_R2: assert property (@(posedge clk) disable iff (rst)
        (frame_done && frame_edges < WAKE_THR) |-> (mode == PM_SHUTDOWN && !powered && !result_valid));

    // R3: a long frame leaves the device in normal mode
    assert_long_normal_R3: assert property (@(posedge clk) disable iff (rst)
        (frame_done && frame_edges >= WAKE_THR) |-> (mode == PM_NORMAL));

    // R6: a valid result only exists in normal mode and only changes at frame end
    assert_valid_normal_R6: assert property (@(posedge clk) disable iff (rst)
        result_valid |-> (mode == PM_NORMAL));
    assert_valid_at_end_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(result_valid) |-> frame_done);

    // R5: wake-up progress is lost only at a frame end
    assert_powered_drop_R5: assert property (@(posedge clk) disable iff (rst)
        $fell(powered) |-> frame_done);

endmodule

// File: rtl/pwrmode_tracker.sv
module pwrmode_tracker
    import pwrtrk_pkg::*;
#(
    parameter int CNT_W         = DEF_CNT_W,
    parameter int WAKE_EDGE     = DEF_WAKE_EDGE,
    parameter int POWERUP_EDGES = DEF_POWERUP_EDGES,
    parameter int SYNC_STAGES   = DEF_SYNC_STAGES
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             boot_normal_i,
    input  logic             cs_n_i,
    input  logic             sclk_i,
    output logic             mode_o,
    output logic             powered_o,
    output logic             result_valid_o,
    output logic             frame_done_o,
    output logic [CNT_W-1:0] frame_edges_o
);
    logic     cs_lvl, cs_prv, sclk_lvl, sclk_prv;
    pin_evt_t evt;
    logic [CNT_W-1:0] edge_cnt;
    logic     edge_tick;
    pmode_e   mode;

    pwrtrk_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_cs_sync (
        .clk(clk), .rst(rst), .din(cs_n_i), .level(cs_lvl), .prev(cs_prv)
    );

    pwrtrk_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sclk_sync (
        .clk(clk), .rst(rst), .din(sclk_i), .level(sclk_lvl), .prev(sclk_prv)
    );

    assign evt = decode_pins(cs_lvl, cs_prv, sclk_lvl, sclk_prv);

    pwrtrk_frame_cnt #(.CNT_W(CNT_W)) u_cnt (
        .clk       (clk),
        .rst       (rst),
        .cs_high   (evt.cs_high),
        .cs_fall   (evt.cs_fall),
        .sclk_fall (evt.sclk_fall),
        .edge_cnt  (edge_cnt),
        .edge_tick (edge_tick)
    );

    pwrtrk_mode_fsm #(
        .CNT_W(CNT_W), .WAKE_EDGE(WAKE_EDGE), .POWERUP_EDGES(POWERUP_EDGES)
    ) u_fsm (
        .clk          (clk),
        .rst          (rst),
        .boot_normal  (boot_normal_i),
        .cs_rise      (evt.cs_rise),
        .edge_tick    (edge_tick),
        .edge_cnt     (edge_cnt),
        .mode         (mode),
        .powered      (powered_o),
        .result_valid (result_valid_o),
        .frame_done   (frame_done_o),
        .frame_edges  (frame_edges_o)
    );

    assign mode_o = (mode == PM_NORMAL);

    // R8: a frame-done pulse needs chip-select seen high by the synchronizer
    assert_done_after_sync_R8: assert property (@(posedge clk) disable iff (rst)
        frame_done_o |-> cs_prv);

endmodule

// File: tb/pwrmode_tracker_tb_top.sv
module pwrmode_tracker_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       boot_normal_i = 1'b0;
    logic       cs_n_i = 1'b1;
    logic       sclk_i = 1'b1;
    logic       mode_o, powered_o, result_valid_o, frame_done_o;
    logic [4:0] frame_edges_o;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    // model state
    int m_mode, m_wake, m_dummy, m_valid, m_edges;

    always #2 clk = ~clk;

    pwrmode_tracker dut_i (
        .clk(clk), .rst(rst), .boot_normal_i(boot_normal_i),
        .cs_n_i(cs_n_i), .sclk_i(sclk_i),
        .mode_o(mode_o), .powered_o(powered_o), .result_valid_o(result_valid_o),
        .frame_done_o(frame_done_o), .frame_edges_o(frame_edges_o)
    );

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int sat_edges(input int n);
        return (n > 31) ? 31 : n;
    endfunction

    function automatic int wake_after(input int w, input int n);
        return (w + n > 16) ? 16 : w + n;
    endfunction

    task automatic do_reset(input bit boot);
        boot_normal_i = boot;
        cs_n_i = 1'b1;
        sclk_i = 1'b1;
        rst = 1'b1;
        tick(3);
        chk("R1 mode in reset", mode_o, boot);
        rst = 1'b0;
        tick(2);
        chk("R1 mode", mode_o, boot);
        chk("R1 powered", powered_o, 0);
        chk("R1 valid", result_valid_o, 0);
        chk("R1 done", frame_done_o, 0);
        chk("R1 edges", frame_edges_o, 0);
        m_mode = boot; m_wake = 0; m_dummy = 0; m_valid = 0; m_edges = 0;
    endtask

    task automatic pulses(input int n);
        for (int i = 0; i < n; i++) begin
            sclk_i = 1'b0;
            tick(3);
            sclk_i = 1'b1;
            tick(3);
        end
    endtask

    task automatic open_frame();
        cs_n_i = 1'b0;
        tick(4);
    endtask

    // closes a frame of n counted edges and checks all outputs against the model
    task automatic close_frame(input int n);
        tick(2);
        m_wake = wake_after(m_wake, n);
        m_edges = sat_edges(n);
        if (n < 10) begin
            m_mode = 0; m_wake = 0; m_dummy = 0; m_valid = 0;
        end else begin
            m_mode = 1; m_valid = m_dummy; m_dummy = 1;
        end
        cs_n_i = 1'b1;
        tick(2);
        chk("R8 done not early", frame_done_o, 0);
        tick(1);
        chk("R8 done at third edge", frame_done_o, 1);
        chk("R4 edges", frame_edges_o, m_edges);
        if (n < 10) chk("R2 mode", mode_o, m_mode);
        else        chk("R3 mode", mode_o, m_mode);
        chk("R5 powered", powered_o, (m_wake == 16) ? 1 : 0);
        chk("R6 valid", result_valid_o, m_valid);
        tick(1);
        chk("R4 done one cycle", frame_done_o, 0);
        chk("R4 edges held", frame_edges_o, m_edges);
    endtask

    task automatic frame(input int n);
        open_frame();
        pulses(n);
        close_frame(n);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        do_reset(1'b0);

        // R7: idle pulses with chip-select high
        pulses(20);
        chk("R7 idle no wake", powered_o, 0);
        chk("R7 idle no frame", frame_done_o, 0);
        frame(12);               // wakes, dummy: valid 0, edges 12

        // R5: powered rises at the 16th accumulated edge, mid-frame
        open_frame();
        pulses(3);
        chk("R5 powered before 16", powered_o, 0);
        pulses(1);
        chk("R5 powered at 16", powered_o, 1);
        close_frame(4);          // short frame: shutdown, powered cleared

        // wake-up within one frame from shutdown
        open_frame();
        pulses(15);
        chk("R5 powered at 15", powered_o, 0);
        pulses(1);
        chk("R5 powered at 16 in frame", powered_o, 1);
        close_frame(16);         // dummy frame
        frame(20);               // valid frame (R6)

        // R4: saturation
        frame(40);

        // boot into normal mode, threshold boundaries
        do_reset(1'b1);
        frame(10);               // dummy
        frame(10);               // valid, powered
        frame(9);                // shutdown
        frame(0);                // empty frame stays shutdown
        frame(10);               // dummy again after shutdown

        // random mix
        for (int k = 0; k < 60; k++) begin
            if ($urandom_range(0, 9) == 0) do_reset($urandom_range(0, 1) == 1);
            pulses($urandom_range(0, 3));
            frame($urandom_range(0, 40));
        end

        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule